// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Controller

This block is a register-mapped controller for a bank of general-purpose pins, up to 62 by default. Software reaches it through a single-cycle 32-bit register port and sets, per pin, the direction, the driven value, the interrupt enable and the edge polarity. It reads back a pin level that follows the drive value for outputs and the sampled pin for inputs.

Each input passes through two synchronising flops. The synchronised value is then compared with its own registered previous value to find rising and falling edges. An edge that matches the programmed polarity is latched into an "assert" status bank. The opposite edge is latched into a "deassert" status bank. To take interrupts on both edges, software sets polarity to 1 and watches both banks.

Each status bank drives its own level interrupt. The interrupt stays high until software clears every set bit in that bank. A status word holds 31 pins. Its bit 0 is not a pin flag: on a write it selects whether the other ones in the word set or clear their bits.

Top module: `gpio_irq_ctrl`

Address map. `addr_i` is a word address. Bits [5:2] select the register group and bits [1:0] select the word within that group.

| Group | addr_i[5:2] | Access |
|-------|-------------|--------|
| direction | 0 | read/write |
| drive value | 1 | read/write |
| pin level | 2 | read only |
| interrupt enable | 3 | read/write |
| polarity | 4 | read/write |
| assert status | 5 | bit 0 selects set or clear |
| deassert status | 6 | bit 0 selects set or clear |

## Requirements
- R1: After reset, every register reads 0, `pins_o` and `pins_oe_o` are 0, and both interrupt outputs are low.
- R2: The direction, drive, enable and polarity groups pack pin n at word n/32, bit n mod 32. `pins_oe_o` follows the direction bits and `pins_o` follows the drive bits one cycle after the write.
- R3: Reading the pin-level group returns, for each pin, the drive bit when its direction bit is 1 and the synchronised input otherwise. An input change is visible on the second clock edge after it occurs.
- R4: With polarity 1 and the enable bit set, a rising input sets the pin's assert status bit and a falling input sets its deassert status bit. Pin n maps to status word n/31, bit (n mod 31)+1. The bit is readable on the third clock edge after the pin change.
- R5: With polarity 0 and the enable bit set, a falling input sets the assert status bit and a rising input sets the deassert status bit.
- R6: With the enable bit clear, edges on that pin change no status bit and raise no interrupt.
- R7: A status write with bit 0 = 1 sets every bit in [31:1] written as 1 and leaves the bits written as 0 unchanged.
- R8: A status write with bit 0 = 0 clears every bit in [31:1] written as 1 and leaves the bits written as 0 unchanged.
- R9: Status bit 0 always reads 0. Bits with no pin behind them read 0. Unmapped groups and words read 0.
- R10: Each interrupt output is high exactly while its bank holds a set bit, and it stays high until software clears those bits.
- R11: A hardware edge on a pin in the same cycle as a software clear of its status bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address: group [5:2], word [1:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| pins_o | output | NUM_PINS | Pin drive values |
| pins_oe_o | output | NUM_PINS | Pin output enables |
| irq_assert_o | output | 1 | Assert bank interrupt, level |
| irq_deassert_o | output | 1 | Deassert bank interrupt, level |

## Verification
The hardest case to reach from the ports is a clear write that coincides exactly with an edge event. The event reaches the status logic only after two synchroniser stages and the edge register. The bench therefore changes a pin on a falling clock edge, counts two rising edges, and presents the clear write so that it commits on the third rising edge, the same edge on which the event lands. A table of per-pin cases then covers both polarities, disabled pins, the first and last pin of each status word, and a level that does not change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  typedef enum logic [3:0] {
    GRP_DIR   = 4'd0,
    GRP_DOUT  = 4'd1,
    GRP_LEVEL = 4'd2,
    GRP_IE    = 4'd3,
    GRP_POL   = 4'd4,
    GRP_ASTAT = 4'd5,
    GRP_DSTAT = 4'd6
  } grp_e;

  function automatic int div_up(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 62
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_stat_bank.sv
module gpio_stat_bank #(
  parameter int NUM_PINS = 62,
  parameter int NS       = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] ev_i,
  input  logic                wr_i,
  input  logic [1:0]          wr_word_i,
  input  logic [31:0]         wdata_i,
  output logic [NS*32-1:0]    stat_o,
  output logic                irq_o
);
  for (genvar w = 0; w < NS; w++) begin : g_word
    logic hit;
    assign hit = wr_i && (int'(wr_word_i) == w);
    assign stat_o[w*32] = 1'b0;  // selector position, never a flag
    for (genvar b = 1; b < 32; b++) begin : g_bit
      localparam int PIN = w*31 + b - 1;
      if (PIN < NUM_PINS) begin : g_live
        logic st_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                   st_q <= 1'b0;
          else if (ev_i[PIN])            st_q <= 1'b1;  // event beats clear
          else if (hit && wdata_i[b])    st_q <= wdata_i[0];
        end
        assign stat_o[w*32+b] = st_q;
      end else begin : g_dead
        assign stat_o[w*32+b] = 1'b0;
      end
    end
  end

  assign irq_o = |stat_o;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 62
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [5:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] pins_o,
  output logic [NUM_PINS-1:0] pins_oe_o,
  output logic                irq_assert_o,
  output logic                irq_deassert_o
);
  localparam int NW = div_up(NUM_PINS, 32);
  localparam int NS = div_up(NUM_PINS, 31);
  localparam int PW = NW * 32;

  logic [3:0] grp;
  logic [1:0] slot;
  logic       wr;
  assign grp  = addr_i[5:2];
  assign slot = addr_i[1:0];
  assign wr   = req_i && we_i;

  logic [PW-1:0] dir_q, dout_q, ie_q, pol_q, sync_pad;
  logic [NUM_PINS-1:0] sync_lv, rise, fall, ev_a, ev_d;

  for (genvar w = 0; w < NW; w++) begin : g_cfg
    localparam int LO  = w * 32;
    localparam int CNT = (NUM_PINS - LO) < 32 ? (NUM_PINS - LO) : 32;
    localparam logic [31:0] MASK = (CNT == 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT) - 32'd1);
    logic sel;
    assign sel = wr && (int'(slot) == w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q[LO+:32]  <= '0;
        dout_q[LO+:32] <= '0;
        ie_q[LO+:32]   <= '0;
        pol_q[LO+:32]  <= '0;
      end else if (sel) begin
        case (grp)
          GRP_DIR:  dir_q[LO+:32]  <= wdata_i & MASK;
          GRP_DOUT: dout_q[LO+:32] <= wdata_i & MASK;
          GRP_IE:   ie_q[LO+:32]   <= wdata_i & MASK;
          GRP_POL:  pol_q[LO+:32]  <= wdata_i & MASK;
          default: ;
        endcase
      end
    end
  end

  gpio_in_sync #(.N(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins_i),
    .level_o(sync_lv),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    sync_pad = '0;
    sync_pad[NUM_PINS-1:0] = sync_lv;
  end

  logic [NUM_PINS-1:0] ie_p, pol_p;
  assign ie_p  = ie_q[NUM_PINS-1:0];
  assign pol_p = pol_q[NUM_PINS-1:0];
  assign ev_a  = ie_p & ((pol_p & rise) | (~pol_p & fall));
  assign ev_d  = ie_p & ((pol_p & fall) | (~pol_p & rise));

  logic [NS*32-1:0] astat_w, dstat_w;

  gpio_stat_bank #(.NUM_PINS(NUM_PINS), .NS(NS)) u_abank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_a),
    .wr_i     (wr && grp == GRP_ASTAT),
    .wr_word_i(slot),
    .wdata_i  (wdata_i),
    .stat_o   (astat_w),
    .irq_o    (irq_assert_o)
  );

  gpio_stat_bank #(.NUM_PINS(NUM_PINS), .NS(NS)) u_dbank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_d),
    .wr_i     (wr && grp == GRP_DSTAT),
    .wr_word_i(slot),
    .wdata_i  (wdata_i),
    .stat_o   (dstat_w),
    .irq_o    (irq_deassert_o)
  );

  logic [PW-1:0] level_w;
  assign level_w = (dir_q & dout_q) | (~dir_q & sync_pad);

  logic in_nw, in_ns;
  assign in_nw = int'(slot) < NW;
  assign in_ns = int'(slot) < NS;

  always_comb begin
    rdata_o = '0;
    case (grp)
      GRP_DIR:   if (in_nw) rdata_o = dir_q[int'(slot)*32+:32];
      GRP_DOUT:  if (in_nw) rdata_o = dout_q[int'(slot)*32+:32];
      GRP_LEVEL: if (in_nw) rdata_o = level_w[int'(slot)*32+:32];
      GRP_IE:    if (in_nw) rdata_o = ie_q[int'(slot)*32+:32];
      GRP_POL:   if (in_nw) rdata_o = pol_q[int'(slot)*32+:32];
      GRP_ASTAT: if (in_ns) rdata_o = astat_w[int'(slot)*32+:32];
      GRP_DSTAT: if (in_ns) rdata_o = dstat_w[int'(slot)*32+:32];
      default:   rdata_o = '0;
    endcase
  end

  assign pins_o    = dout_q[NUM_PINS-1:0];
  assign pins_oe_o = dir_q[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 62
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  req_i,
  input logic                                  we_i,
  input logic [5:0]                            addr_i,
  input logic [31:0]                           wdata_i,
  input logic [31:0]                           rdata_o,
  input logic [NUM_PINS-1:0]                   pins_oe_o,
  input logic                                  irq_assert_o,
  input logic [((NUM_PINS+31)/32)*32-1:0]      ie_q,
  input logic [((NUM_PINS+30)/31)*32-1:0]      astat_w
);
  localparam int LOW = NUM_PINS < 32 ? NUM_PINS : 32;
  localparam int M0  = NUM_PINS < 31 ? NUM_PINS : 31;
  localparam logic [31:0] SMASK0 = ((32'd1 << M0) - 32'd1) << 1;

  logic wr_dir0, wr_a0_set, wr_a_clr, wr_a_set;
  assign wr_dir0   = req_i && we_i && addr_i == 6'd0;
  assign wr_a_set  = req_i && we_i && addr_i[5:2] == 4'd5 && wdata_i[0];
  assign wr_a_clr  = req_i && we_i && addr_i[5:2] == 4'd5 && !wdata_i[0];
  assign wr_a0_set = wr_a_set && addr_i[1:0] == 2'd0;

  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir0 |=> pins_oe_o[LOW-1:0] == $past(wdata_i[LOW-1:0])); // R2

  AST_STAT_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[5:2] == 4'd5 || addr_i[5:2] == 4'd6) |-> !rdata_o[0]); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[5:2] > 4'd6) |-> rdata_o == 32'd0); // R9

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a0_set |=> ((astat_w[31:0] & $past(wdata_i) & SMASK0) == ($past(wdata_i) & SMASK0))); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_assert_o && !wr_a_clr) |=> irq_assert_o); // R10

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_assert_o) |-> ($past(|ie_q) || $past(wr_a_set))); // R6
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NP = 62;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [5:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pins_i = '0;
  logic [NP-1:0] pins_o, pins_oe_o;
  logic          irq_assert_o, irq_deassert_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl #(.NUM_PINS(NP)) u_dut (.*);

  localparam logic [5:0] A_DIR = 6'd0, A_DOUT = 6'd4, A_LVL = 6'd8,
                         A_IE = 6'd12, A_POL = 6'd16, A_AST = 6'd20, A_DST = 6'd24;

  // {pin[5:0], pol, ie, from, to, exp_assert, exp_deassert}
  localparam int NV = 10;
  localparam logic [NV-1:0][11:0] VEC = {
    {6'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {6'd30, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {6'd30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {6'd31, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {6'd61, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {6'd45, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'd32, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {6'd61, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {6'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    for (int g = 0; g < 7; g++) begin
      rd(6'(g*4), r); chk("R1 word0", r, 32'h0);
      rd(6'(g*4+1), r); chk("R1 word1", r, 32'h0);
    end
    chk("R1 pins", {pins_oe_o[31:0]} | pins_o[31:0], 32'h0);
    chk("R1 irqs", {30'd0, irq_assert_o, irq_deassert_o}, 32'h0);

    // table of edge cases: R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      automatic int p = int'(VEC[NV-1-v][11:6]);
      automatic logic pol = VEC[NV-1-v][5];
      automatic logic ie  = VEC[NV-1-v][4];
      automatic int sw = p / 31;
      automatic logic [31:0] sbit = 32'd1 << (p % 31 + 1);
      automatic logic [31:0] pbit = 32'd1 << (p % 32);
      automatic logic [5:0] cw = 6'(p / 32);
      wr(A_IE + cw, ie ? pbit : 32'h0);
      wr(A_POL + cw, pol ? pbit : 32'h0);
      @(negedge clk_i) pins_i[p] = VEC[NV-1-v][3];
      repeat (5) @(posedge clk_i);
      wr(A_AST + 6'(sw), 32'hFFFF_FFFE);
      wr(A_DST + 6'(sw), 32'hFFFF_FFFE);
      @(negedge clk_i) pins_i[p] = VEC[NV-1-v][2];
      repeat (5) @(posedge clk_i);
      rd(A_AST + 6'(sw), r); chk("R4 R5 R6 assert bank", r, VEC[NV-1-v][1] ? sbit : 32'h0);
      rd(A_DST + 6'(sw), r); chk("R4 R5 R6 deassert bank", r, VEC[NV-1-v][0] ? sbit : 32'h0);
      chk("R10 irq levels", {30'd0, irq_assert_o, irq_deassert_o},
          {30'd0, VEC[NV-1-v][1], VEC[NV-1-v][0]});
      wr(A_AST + 6'(sw), 32'hFFFF_FFFE);
      wr(A_DST + 6'(sw), 32'hFFFF_FFFE);
      wr(A_IE + cw, 32'h0);
      wr(A_POL + cw, 32'h0);
      pins_i = '0;
      repeat (5) @(posedge clk_i);
    end

    // R2 drive and direction
    wr(A_DOUT, 32'h1234_5678);
    wr(A_DIR, 32'h0000_FFFF);
    chk("R2 pins_o", pins_o[31:0], 32'h1234_5678);
    chk("R2 pins_oe_o", pins_oe_o[31:0], 32'h0000_FFFF);
    wr(A_DOUT + 6'd1, 32'hFFFF_FFFF);
    chk("R2 pins_o high word", {2'b00, pins_o[61:32]}, 32'h3FFF_FFFF);
    rd(A_DOUT + 6'd1, r); chk("R9 unbacked drive bits", r, 32'h3FFF_FFFF);

    // R3 level mux
    @(negedge clk_i) pins_i[31:0] = 32'hCAFE_BABE;
    @(posedge clk_i);
    @(posedge clk_i);
    rd(A_LVL, r); chk("R3 level mix", r, 32'hCAFE_5678);
    wr(A_DIR, 32'h0);
    wr(A_DOUT, 32'h0);
    wr(A_DOUT + 6'd1, 32'h0);
    pins_i = '0;
    repeat (4) @(posedge clk_i);

    // R7 R8 software set and clear
    wr(A_AST, 32'h0000_0F01);
    rd(A_AST, r); chk("R7 set", r, 32'h0000_0F00);
    chk("R10 irq after set", {31'd0, irq_assert_o}, 32'd1);
    wr(A_AST, 32'h0003_0001);
    rd(A_AST, r); chk("R7 set keeps others", r, 32'h0003_0F00);
    wr(A_AST, 32'h0000_0100);
    rd(A_AST, r); chk("R8 clear one", r, 32'h0003_0E00);
    chk("R10 irq held", {31'd0, irq_assert_o}, 32'd1);
    wr(A_AST, 32'hFFFF_FFFE);
    rd(A_AST, r); chk("R8 clear all", r, 32'h0);
    chk("R10 irq drops", {31'd0, irq_assert_o}, 32'd0);
    wr(A_DST, 32'h0000_0001);
    rd(A_DST, r); chk("R9 bit0 reads zero", r, 32'h0);
    chk("R9 selector alone raises nothing", {31'd0, irq_deassert_o}, 32'd0);

    // R9 unmapped
    rd(6'd60, r); chk("R9 unmapped group", r, 32'h0);
    wr(A_DIR + 6'd2, 32'hFFFF_FFFF);
    rd(A_DIR + 6'd2, r); chk("R9 unmapped word", r, 32'h0);
    rd(A_AST + 6'd3, r); chk("R9 unmapped status word", r, 32'h0);

    // R11 edge coincides with clear: pin 7, rising, polarity 1
    wr(A_IE, 32'h0000_0080);
    wr(A_POL, 32'h0000_0080);
    wr(A_AST, 32'h0000_0101);
    @(negedge clk_i) pins_i[7] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = A_AST; wdata_i = 32'h0000_0100;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    rd(A_AST, r); chk("R11 event beats clear", r, 32'h0000_0100);
    wr(A_AST, 32'h0000_0100);
    rd(A_AST, r); chk("R8 later clear works", r, 32'h0);

    finish_run();
  end
endmodule